// File: doc/BRIEF.md
# Matrix Keypad Scanner

This block scans a key matrix without software help. The matrix has up to five drive columns and six sense rows. While the block has nothing to do, it holds every column low so that any press pulls a row down. Once a press is seen and holds for a programmable debounce time, the block drives one column low at a time. It checks the active rows in ascending order, one row per scan interval, and visits the columns in an order that software programs. A scan that finds exactly one closed key loads that key's column and row into the result registers and raises a one-cycle interrupt. A scan that finds several keys reports nothing. In both cases the block then waits for a debounced release before it returns to idle.

All timing is counted on `tick_i`, a one-cycle pulse at roughly 1 kHz that comes from outside the block. The debounce time is `(dbnc_sel_i+1)*4` ticks. The interval between row checks is `gap_sel_i+1` ticks. When `scan_en_i` is low, the block is in bypass. The columns then follow `man_col_i` directly, and software reads the synchronised rows on `row_sync_o` to scan the keypad itself.

The block has no streaming interface. A result is posted and the interrupt pulses whether or not software has read the previous result, so there is no back-pressure. The result outputs are plain registers.

Top module: `kpad_scan_top`

## Requirements
- R1: With `scan_en_i` high and no active row low, all bits of `col_o` are 0 and no column scan begins.
- R2: A press must still read low after `(dbnc_sel_i+1)*4` ticks before scanning starts. A press released before that time leads back to idle and causes no scan.
- R3: During a scan, exactly one bit of `col_o` is 0 at a time. Each column stays driven for `act_rows_i*(gap_sel_i+1)` ticks, with the active rows checked in ascending order.
- R4: `col_order_i` holds five 3-bit column indices. Bits [2:0] are the first slot scanned and bits [14:12] the last. Slots are visited in that order.
- R5: A scan that finds exactly one key loads its column index into `key_col_o` and its row index into `key_row_o`. `key_irq_o` is high for exactly one clock in the cycle those outputs change.
- R6: A scan that finds two or more keys gives no interrupt and leaves `key_col_o` and `key_row_o` unchanged.
- R7: After a scan, the block waits until no active row is low, then for `(dbnc_sel_i+1)*4` ticks. A re-press during that wait restarts it. A key that stays held, or is re-pressed within the wait, gives no second interrupt.
- R8: With `scan_en_i` low, `col_o` equals `man_col_i` in the same cycle, even mid-scan, and scanning stops. `row_sync_o` shows `row_i` after two clock edges.
- R9: Only rows below `act_rows_i` are used, both to detect a press and to locate a key. A slot whose index is at or above `act_cols_i`, or at or above 5, is skipped.
- R10: After reset, `key_col_o` and `key_row_o` are 0 and `key_irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle millisecond timebase pulse |
| scan_en_i | input | 1 | 1 = hardware scanning, 0 = bypass |
| dbnc_sel_i | input | 8 | Debounce setting, wait = (value+1)*4 ticks |
| gap_sel_i | input | 2 | Row check interval, (value+1) ticks |
| act_cols_i | input | 3 | Number of active columns |
| act_rows_i | input | 3 | Number of active rows |
| col_order_i | input | 15 | Five packed 3-bit column indices, first slot in the low bits |
| man_col_i | input | 5 | Column drive value used in bypass |
| row_i | input | 6 | Raw sense rows, low = key closed |
| col_o | output | 5 | Column drive, low = column selected |
| row_sync_o | output | 6 | Synchronised sense rows |
| key_col_o | output | 3 | Column index of the last valid key |
| key_row_o | output | 3 | Row index of the last valid key |
| key_irq_o | output | 1 | One-cycle pulse when a valid key is stored |

## Verification
The bench builds the block with its default parameters: five columns, six rows, an 8-bit debounce field and four ticks per debounce step. It supplies a tick every four clocks, so debounce settings 0 and 2 and both short scan intervals give whole scans within a few hundred cycles. Several scan orders, out-of-range slots, reduced row and column counts, double presses, short releases and a bypass entered mid-scan are all exercised at full parameter width.

// File: rtl/kpad_pkg.sv
package kpad_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PDB,
    ST_SCAN,
    ST_WREL,
    ST_RDB
  } kp_state_t;
endpackage

// File: rtl/kpad_sync.sv
module kpad_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= '1;
        else if (g == 0) stg[g] <= d_i;
        else stg[g] <= stg[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/kpad_timer.sv
module kpad_timer #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         done_o
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (load_i) cnt <= load_val_i;
    else if (tick_i && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign done_o = (cnt == '0);

  // R2
  tmr_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && load_val_i != '0) |=> !done_o);
endmodule

// File: rtl/kpad_order.sv
module kpad_order #(
  parameter int COLS = 5,
  parameter int CW   = 3,
  parameter int ACW  = 3
) (
  input  logic [COLS*CW-1:0] order_i,
  input  logic [ACW-1:0]     act_cols_i,
  input  logic [CW-1:0]      slot_i,
  output logic [CW-1:0]      col_idx_o,
  output logic               valid_o
);
  logic [CW-1:0] slot_tab [COLS];

  genvar g;
  generate
    for (g = 0; g < COLS; g++) begin : g_slot
      assign slot_tab[g] = order_i[g*CW +: CW];
    end
  endgenerate

  always_comb begin
    col_idx_o = '0;
    for (int s = 0; s < COLS; s++)
      if (slot_i == CW'(s)) col_idx_o = slot_tab[s];
  end

  assign valid_o = (32'(col_idx_o) < COLS) && (32'(col_idx_o) < 32'(act_cols_i));
endmodule

// File: rtl/kpad_scan_top.sv
module kpad_scan_top
  import kpad_pkg::*;
#(
  parameter int COLS    = 5,
  parameter int ROWS    = 6,
  parameter int DB_W    = 8,
  parameter int SC_W    = 2,
  parameter int DB_STEP = 4,
  parameter int SETTLE  = 3,
  localparam int CW     = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int RW     = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int ACW    = $clog2(COLS + 1),
  localparam int ARW    = $clog2(ROWS + 1),
  localparam int ORD_W  = COLS * CW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             scan_en_i,
  input  logic [DB_W-1:0]  dbnc_sel_i,
  input  logic [SC_W-1:0]  gap_sel_i,
  input  logic [ACW-1:0]   act_cols_i,
  input  logic [ARW-1:0]   act_rows_i,
  input  logic [ORD_W-1:0] col_order_i,
  input  logic [COLS-1:0]  man_col_i,
  input  logic [ROWS-1:0]  row_i,
  output logic [COLS-1:0]  col_o,
  output logic [ROWS-1:0]  row_sync_o,
  output logic [CW-1:0]    key_col_o,
  output logic [RW-1:0]    key_row_o,
  output logic             key_irq_o
);
  localparam int TMR_W = $clog2((2**DB_W) * DB_STEP + 1);
  localparam int STW   = $clog2(SETTLE + 1);

  kp_state_t      state, st_n;
  logic [CW-1:0]  slot, slot_n;
  logic [RW-1:0]  row_ix, row_n;
  logic [1:0]     hits, hits_n;
  logic [CW-1:0]  hit_col, hcol_n;
  logic [RW-1:0]  hit_row, hrow_n;
  logic [STW-1:0] settle, settle_n;
  logic [CW-1:0]  kcol_n;
  logic [RW-1:0]  krow_n;
  logic           irq_n;
  logic           adv;

  logic [ROWS-1:0]  row_s, row_mask, low_vec;
  logic             any_low;
  logic [CW-1:0]    col_idx;
  logic             slot_ok;
  logic             tmr_ld, tmr_done;
  logic [TMR_W-1:0] tmr_val, db_ticks, gap_ticks;
  logic             settled;

  kpad_sync #(.W(ROWS), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(row_i), .q_o(row_s)
  );

  kpad_timer #(.W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .load_i(tmr_ld), .load_val_i(tmr_val), .done_o(tmr_done)
  );

  kpad_order #(.COLS(COLS), .CW(CW), .ACW(ACW)) u_ord (
    .order_i(col_order_i), .act_cols_i(act_cols_i), .slot_i(slot),
    .col_idx_o(col_idx), .valid_o(slot_ok)
  );

  assign db_ticks  = TMR_W'((32'(dbnc_sel_i) + 32'd1) * 32'(DB_STEP));
  assign gap_ticks = TMR_W'(32'(gap_sel_i) + 32'd1);
  assign settled   = (32'(settle) >= SETTLE);

  always_comb begin
    for (int r = 0; r < ROWS; r++) row_mask[r] = (32'(act_rows_i) > r);
  end
  assign low_vec    = ~row_s & row_mask;
  assign any_low    = |low_vec;
  assign row_sync_o = row_s;

  always_comb begin
    st_n     = state;
    slot_n   = slot;
    row_n    = row_ix;
    hits_n   = hits;
    hcol_n   = hit_col;
    hrow_n   = hit_row;
    settle_n = settled ? settle : settle + 1'b1;
    kcol_n   = key_col_o;
    krow_n   = key_row_o;
    irq_n    = 1'b0;
    tmr_ld   = 1'b0;
    tmr_val  = db_ticks;
    adv      = 1'b0;
    if (!scan_en_i) begin
      st_n = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: begin
          if (any_low) begin
            tmr_ld = 1'b1;
            st_n   = ST_PDB;
          end
        end
        ST_PDB: begin
          if (tmr_done) begin
            if (any_low) begin
              st_n     = ST_SCAN;
              slot_n   = '0;
              row_n    = '0;
              hits_n   = '0;
              settle_n = '0;
              tmr_ld   = 1'b1;
              tmr_val  = gap_ticks;
            end else begin
              st_n = ST_IDLE;
            end
          end
        end
        ST_SCAN: begin
          if (!slot_ok) begin
            adv = 1'b1;
          end else if (tmr_done && settled) begin
            if (!row_s[row_ix]) begin
              if (hits == 2'd0) begin
                hcol_n = col_idx;
                hrow_n = row_ix;
              end
              hits_n = (hits == 2'd0) ? 2'd1 : 2'd2;
            end
            if (32'(row_ix) + 1 >= 32'(act_rows_i)) begin
              adv = 1'b1;
            end else begin
              row_n   = row_ix + 1'b1;
              tmr_ld  = 1'b1;
              tmr_val = gap_ticks;
            end
          end
        end
        ST_WREL: begin
          if (!any_low) begin
            tmr_ld = 1'b1;
            st_n   = ST_RDB;
          end
        end
        ST_RDB: begin
          if (any_low) st_n = ST_WREL;
          else if (tmr_done) st_n = ST_IDLE;
        end
        default: st_n = ST_IDLE;
      endcase
      if (adv) begin
        if (32'(slot) >= COLS - 1) begin
          st_n = ST_WREL;
          if (hits_n == 2'd1) begin
            irq_n  = 1'b1;
            kcol_n = hcol_n;
            krow_n = hrow_n;
          end
        end else begin
          slot_n   = slot + 1'b1;
          row_n    = '0;
          settle_n = '0;
          tmr_ld   = 1'b1;
          tmr_val  = gap_ticks;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      slot      <= '0;
      row_ix    <= '0;
      hits      <= '0;
      hit_col   <= '0;
      hit_row   <= '0;
      settle    <= '0;
      key_col_o <= '0;
      key_row_o <= '0;
      key_irq_o <= 1'b0;
    end else begin
      state     <= st_n;
      slot      <= slot_n;
      row_ix    <= row_n;
      hits      <= hits_n;
      hit_col   <= hcol_n;
      hit_row   <= hrow_n;
      settle    <= settle_n;
      key_col_o <= kcol_n;
      key_row_o <= krow_n;
      key_irq_o <= irq_n;
    end
  end

  always_comb begin
    if (!scan_en_i) col_o = man_col_i;
    else if (state == ST_SCAN) col_o = slot_ok ? ~(COLS'(1) << col_idx) : '1;
    else col_o = '0;
  end

  // R5
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_irq_o |=> !key_irq_o);

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(key_col_o) && $stable(key_row_o)) |-> key_irq_o);

  // R3
  scan_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en_i && state == ST_SCAN) |-> $countones(~col_o) <= 1);

  // R8
  bypass_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en_i |=> (state == ST_IDLE && !key_irq_o));
endmodule

// File: tb/sim_kpad_scan_top.sv
module sim_kpad_scan_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic scan_en = 1'b1;
  logic [7:0] dbnc = 8'd0;
  logic [1:0] gap = 2'd0;
  logic [2:0] acols = 3'd5;
  logic [2:0] arows = 3'd6;
  logic [14:0] order;
  logic [4:0] man_col = 5'h1f;
  logic [5:0] row_in;
  logic [4:0] col_o;
  logic [5:0] row_sync;
  logic [2:0] key_col, key_row;
  logic key_irq;
  logic [29:0] keys = '0;  // bit c*6+r = key at column c, row r

  int n_chk = 0, n_fail = 0;
  int irq_cnt = 0, irq_wide = 0;
  int seq [64];
  int run_len [64];
  int seq_n = 0, cur = -1, run_start = 0, tick_total = 0, divc = 0;
  bit irq_prev = 0;
  int exp_kc = 0, exp_kr = 0;

  always #2 clk = ~clk;

  function automatic logic [14:0] pk(int a, int b, int c, int d, int e);
    return {3'(e), 3'(d), 3'(c), 3'(b), 3'(a)};
  endfunction

  initial order = pk(0, 1, 2, 3, 4);

  always_comb begin
    for (int r = 0; r < 6; r++) begin
      row_in[r] = 1'b1;
      for (int c = 0; c < 5; c++)
        if (keys[c*6+r] && !col_o[c]) row_in[r] = 1'b0;
    end
  end

  kpad_scan_top u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .scan_en_i(scan_en),
    .dbnc_sel_i(dbnc), .gap_sel_i(gap), .act_cols_i(acols), .act_rows_i(arows),
    .col_order_i(order), .man_col_i(man_col), .row_i(row_in),
    .col_o(col_o), .row_sync_o(row_sync), .key_col_o(key_col),
    .key_row_o(key_row), .key_irq_o(key_irq)
  );

  always @(negedge clk) begin
    divc = (divc + 1) % 4;
    tick = (divc == 0);
  end

  always @(posedge clk) if (tick) tick_total++;

  always @(negedge clk) begin
    int idx, zeros;
    idx = -1; zeros = 0;
    for (int c = 0; c < 5; c++) if (!col_o[c]) begin zeros++; idx = c; end
    if (zeros != 1) idx = -1;
    if (rst_n && scan_en) begin
      if (idx != cur) begin
        if (cur >= 0 && seq_n > 0) run_len[(seq_n-1)%64] = tick_total - run_start;
        if (idx >= 0) begin
          seq[seq_n%64] = idx;
          seq_n++;
          run_start = tick_total;
        end
        cur = idx;
      end
    end
    if (key_irq) begin
      irq_cnt++;
      if (irq_prev) irq_wide++;
    end
    irq_prev = key_irq;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_irq(input int maxc, output bit got);
    int s;
    s = irq_cnt; got = 0;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      if (irq_cnt > s) begin got = 1; break; end
    end
  endtask

  task automatic release_all();
    keys = '0;
    repeat (400) @(negedge clk);
  endtask

  task automatic chk_seq(input int base, input int n, input int e [5], input string req);
    chk(seq_n - base == n, req, seq_n - base, n);
    for (int i = 0; i < n; i++)
      chk(seq[(base+i)%64] == e[i], req, seq[(base+i)%64], e[i]);
  endtask

  task automatic chk_result(input string req);
    chk(int'(key_col) == exp_kc, req, key_col, exp_kc);
    chk(int'(key_row) == exp_kr, req, key_row, exp_kr);
  endtask

  task automatic t_reset();
    chk(key_irq == 1'b0, "R10 irq after reset", key_irq, 0);
    chk(key_col == 3'd0 && key_row == 3'd0, "R10 results after reset", {key_col, key_row}, 0);
    repeat (20) @(negedge clk);
    chk(col_o == 5'd0, "R1 idle columns low", col_o, 0);
    chk(seq_n == 0, "R1 no scan without press", seq_n, 0);
  endtask

  task automatic t_single();
    int base, s; bit got; int e [5];
    e = '{0, 1, 2, 3, 4};
    base = seq_n; s = irq_cnt;
    keys[2*6+3] = 1'b1;
    wait_irq(3000, got);
    chk(got, "R5 irq on single key", got, 1);
    exp_kc = 2; exp_kr = 3;
    chk_result("R5 single key location");
    chk_seq(base, 5, e, "R4 identity order");
    repeat (300) @(negedge clk);
    chk(irq_cnt - s == 1, "R7 held key one irq", irq_cnt - s, 1);
    chk(irq_wide == 0, "R5 irq one cycle", irq_wide, 0);
    release_all();
  endtask

  task automatic t_order();
    int base; bit got; int e [5];
    e = '{3, 1, 4, 0, 2};
    order = pk(3, 1, 4, 0, 2);
    base = seq_n;
    keys[4*6+0] = 1'b1;
    wait_irq(3000, got);
    chk(got, "R4 irq with custom order", got, 1);
    exp_kc = 4; exp_kr = 0;
    chk_result("R4 custom order result");
    chk_seq(base, 5, e, "R4 custom order sequence");
    release_all();
  endtask

  task automatic t_skip();
    int base; bit got; int e [5];
    e = '{2, 0, 1, 0, 0};
    order = pk(2, 7, 0, 5, 1);
    base = seq_n;
    keys[1*6+1] = 1'b1;
    wait_irq(3000, got);
    chk(got, "R9 irq with skipped slots", got, 1);
    exp_kc = 1; exp_kr = 1;
    chk_result("R9 skip result");
    chk_seq(base, 3, e, "R9 out-of-range slots skipped");
    release_all();
    order = pk(0, 1, 2, 3, 4);
  endtask

  task automatic t_multi();
    int base, s; int e [5];
    e = '{0, 1, 2, 3, 4};
    base = seq_n; s = irq_cnt;
    keys[0*6+1] = 1'b1;
    keys[3*6+4] = 1'b1;
    repeat (600) @(negedge clk);
    chk(irq_cnt == s, "R6 no irq for two keys", irq_cnt - s, 0);
    chk_result("R6 results unchanged");
    chk_seq(base, 5, e, "R6 full scan performed");
    release_all();
  endtask

  task automatic t_size();
    int base, s; int e [5];
    e = '{0, 1, 2, 0, 0};
    arows = 3'd4;
    base = seq_n; s = irq_cnt;
    keys[1*6+5] = 1'b1;
    repeat (400) @(negedge clk);
    chk(seq_n == base, "R9 inactive row ignored", seq_n - base, 0);
    chk(irq_cnt == s, "R9 no irq inactive row", irq_cnt - s, 0);
    release_all();
    arows = 3'd6;
    acols = 3'd3;
    base = seq_n;
    keys[3*6+0] = 1'b1;
    repeat (600) @(negedge clk);
    chk_seq(base, 3, e, "R9 columns limited");
    chk(irq_cnt == s, "R9 no irq inactive column", irq_cnt - s, 0);
    chk_result("R9 results unchanged");
    release_all();
    acols = 3'd5;
  endtask

  task automatic t_debounce();
    int base, t; bit seen;
    dbnc = 8'd2;
    base = seq_n;
    keys[0*6+0] = 1'b1;
    repeat (20) @(negedge clk);
    keys = '0;
    repeat (200) @(negedge clk);
    chk(seq_n == base, "R2 short press no scan", seq_n - base, 0);
    t = 0; seen = 0;
    keys[0*6+0] = 1'b1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      t++;
      if (seq_n > base) begin seen = 1; break; end
    end
    chk(seen && t >= 44 && t <= 64, "R2 press debounce delay", t, 50);
    begin bit got; wait_irq(3000, got); end
    exp_kc = 0; exp_kr = 0;
    chk_result("R2 result after debounce");
    release_all();
  endtask

  task automatic t_interval();
    int base; bit got;
    gap = 2'd1; arows = 3'd3; dbnc = 8'd0;
    base = seq_n;
    keys[4*6+2] = 1'b1;
    wait_irq(3000, got);
    exp_kc = 4; exp_kr = 2;
    chk_result("R3 interval result");
    chk(run_len[base%64] >= 5 && run_len[base%64] <= 7, "R3 column hold ticks",
        run_len[base%64], 6);
    release_all();
    gap = 2'd0; arows = 3'd6;
  endtask

  task automatic t_release();
    int s; bit got;
    dbnc = 8'd2;
    keys[1*6+4] = 1'b1;
    wait_irq(3000, got);
    s = irq_cnt;
    exp_kc = 1; exp_kr = 4;
    keys = '0;
    repeat (16) @(negedge clk);
    keys[1*6+4] = 1'b1;
    repeat (400) @(negedge clk);
    chk(irq_cnt == s, "R7 short release no new irq", irq_cnt - s, 0);
    keys = '0;
    repeat (200) @(negedge clk);
    keys[1*6+4] = 1'b1;
    wait_irq(3000, got);
    chk(irq_cnt == s + 1, "R7 new press after release", irq_cnt - s, 1);
    chk_result("R7 result after re-press");
    release_all();
    dbnc = 8'd0;
  endtask

  task automatic t_bypass();
    int base, s;
    base = seq_n; s = irq_cnt;
    keys[2*6+4] = 1'b1;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (seq_n > base) break;
    end
    man_col = 5'b01101;
    scan_en = 1'b0;
    #1;
    chk(col_o == 5'b01101, "R8 bypass drive mid-scan", col_o, 5'b01101);
    repeat (300) @(negedge clk);
    chk(irq_cnt == s, "R8 scan stopped no irq", irq_cnt - s, 0);
    chk(row_sync == 6'b111111, "R8 rows high column off", row_sync, 6'b111111);
    man_col = 5'b11011;
    repeat (3) @(negedge clk);
    chk(row_sync == 6'b101111, "R8 rows follow manual column", row_sync, 6'b101111);
    chk_result("R8 results kept in bypass");
    keys = '0;
    repeat (5) @(negedge clk);
    scan_en = 1'b1;
    repeat (20) @(negedge clk);
    chk(col_o == 5'd0, "R1 columns low after return", col_o, 0);
  endtask

  bit finished = 0;

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_order();
    t_skip();
    t_multi();
    t_size();
    t_debounce();
    t_interval();
    t_release();
    t_bypass();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule